// File: doc/BRIEF.md
# Signed Decimal Display Formatter

This combinational block takes the result of an arithmetic and logic unit and presents it as a signed decimal number on six active-low 7-segment digits. The operation code selects the source. Multiplications show the 16-bit product. Add, subtract and the other arithmetic codes show the 9-bit arithmetic result. Bitwise codes leave the whole display dark.

A negative source is turned into its magnitude by two's-complement negation. The magnitude is converted to binary-coded decimal by an unrolled shift-and-add-3 network and then decoded into segment patterns. A minus sign appears on the top digit when the value is negative. Leading zeros on the magnitude digits are suppressed, but the lowest digit always shows a numeral. The decimal-point segments are never lit.

Top module: `dispFormatter`

## Requirements
- R1: For operation codes 0, 1, 2 and 3, all six digit outputs are 8'hFF, meaning every segment and every decimal point is dark.
- R2: For operation code 7, the displayed value is the 16-bit product read as a signed two's-complement number (range -32768 to 32767).
- R3: For operation codes 4, 5 and 6, the displayed value is the 9-bit arithmetic result read as a signed two's-complement number (range -256 to 255). The product input has no effect for these codes.
- R4: Digit 5 shows a hyphen (8'hBF, segment g only) when the displayed value is negative and is blank (8'hFF) otherwise.
- R5: Digits 4 down to 0 show the decimal magnitude of the value, with digit 0 the units digit. This holds up to a magnitude of 32768.
- R6: Among digits 4 to 1, any digit above the most significant non-zero digit of the magnitude is blank (8'hFF). Digit 0 always shows its numeral, so a value of zero is shown as "0".
- R7: Bit 7 of every digit output, the decimal point, is always 1 (off).
- R8: Bits 6 to 0 of each digit drive segments g, f, e, d, c, b, a in that order, and 0 lights a segment. For example, numeral 0 is 7'b1000000, numeral 1 is 7'b1111001 and numeral 8 is 7'b0000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 3 | Operation code of the current ALU result |
| product | input | 16 | Signed product from the multiplier |
| arithRes | input | 9 | Signed arithmetic result (add, subtract and similar) |
| hex0 | output | 8 | Units digit: {dp, g..a}, active low |
| hex1 | output | 8 | Tens digit |
| hex2 | output | 8 | Hundreds digit |
| hex3 | output | 8 | Thousands digit |
| hex4 | output | 8 | Ten-thousands digit |
| hex5 | output | 8 | Sign digit: hyphen or blank |

## Verification
The checks inside the logic assume that the inputs are settled two's-complement words. They also assume that any 3-bit operation code is legal, so no input pattern is excluded. They look at combinational values once those values have settled, so the bench changes the inputs only on the rising clock edge and reads the outputs half a period later. The stimulus covers both ends of each signed range, zero, and values whose decimal form has internal zeros. It also reuses the same operand words under bitwise and arithmetic codes, so that blanking and source selection are both observed at the pins.

// File: rtl/dispPkg.sv
package dispPkg;
  localparam int PROD_W  = 16;
  localparam int ARITH_W = 9;
  localparam int NUM_DIG = 5;
  localparam int SEG_W   = 8;

  localparam logic [SEG_W-1:0] SEG_BLANK  = 8'hFF;
  localparam logic [SEG_W-1:0] SEG_HYPHEN = 8'hBF;

  typedef struct packed {
    logic blankAll;
    logic useProduct;
  } dispCtrl_t;
endpackage

// File: rtl/dispControl.sv
module dispControl
  import dispPkg::*;
(
  input  logic [2:0] opSel,
  output dispCtrl_t  ctrl
);
  always_comb begin
    ctrl.blankAll   = (opSel[2] == 1'b0);
    ctrl.useProduct = (opSel == 3'd7);
  end

  always_comb begin
    // R2
    useprod_only_mul_chk: assert (!ctrl.useProduct || opSel == 3'd7);
    // R1
    blank_exclusive_chk: assert (!(ctrl.blankAll && ctrl.useProduct));
  end
endmodule

// File: rtl/bcdConvert.sv
module bcdConvert #(
  parameter int BIN_W = 16,
  parameter int DIG   = 5
) (
  input  logic [BIN_W-1:0] binIn,
  output logic [DIG*4-1:0] bcdOut
);
  localparam int WORK_W = BIN_W + DIG*4;

  always_comb begin
    logic [WORK_W-1:0] work;
    work = '0;
    work[BIN_W-1:0] = binIn;
    for (int it = 0; it < BIN_W; it++) begin
      for (int d = 0; d < DIG; d++) begin
        if (work[BIN_W + 4*d +: 4] >= 4'd5)
          work[BIN_W + 4*d +: 4] = work[BIN_W + 4*d +: 4] + 4'd3;
      end
      work = work << 1;
    end
    bcdOut = work[BIN_W +: DIG*4];
  end

  always_comb begin
    for (int d = 0; d < DIG; d++) begin
      // R5
      digit_range_chk: assert (bcdOut[4*d +: 4] <= 4'd9);
    end
  end
endmodule

// File: rtl/segDecode.sv
module segDecode (
  input  logic [3:0] digit,
  output logic [6:0] seg
);
  always_comb begin
    case (digit)
      4'd0: seg = 7'b1000000;
      4'd1: seg = 7'b1111001;
      4'd2: seg = 7'b0100100;
      4'd3: seg = 7'b0110000;
      4'd4: seg = 7'b0011001;
      4'd5: seg = 7'b0010010;
      4'd6: seg = 7'b0000010;
      4'd7: seg = 7'b1111000;
      4'd8: seg = 7'b0000000;
      4'd9: seg = 7'b0010000;
      default: seg = 7'b1111111;
    endcase
  end
endmodule

// File: rtl/dispDatapath.sv
module dispDatapath
  import dispPkg::*;
(
  input  dispCtrl_t          ctrl,
  input  logic [PROD_W-1:0]  product,
  input  logic [ARITH_W-1:0] arithRes,
  output logic [SEG_W-1:0]   hexOut [NUM_DIG+1]
);
  logic [PROD_W-1:0]    srcVal;
  logic                 isNeg;
  logic [PROD_W-1:0]    magVal;
  logic [NUM_DIG*4-1:0] bcdDigits;
  logic [6:0]           rawSeg [NUM_DIG];
  logic [NUM_DIG-1:0]   showDig;

  always_comb begin
    srcVal = ctrl.useProduct ? product
                             : {{(PROD_W-ARITH_W){arithRes[ARITH_W-1]}}, arithRes};
    isNeg  = srcVal[PROD_W-1];
    magVal = isNeg ? (~srcVal + 1'b1) : srcVal;
  end

  bcdConvert #(.BIN_W(PROD_W), .DIG(NUM_DIG)) i_bcd (
    .binIn (magVal),
    .bcdOut(bcdDigits)
  );

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dec
    segDecode i_seg (
      .digit(bcdDigits[4*g +: 4]),
      .seg  (rawSeg[g])
    );
  end

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = NUM_DIG-1; i >= 1; i--) begin
      seen = seen | (bcdDigits[4*i +: 4] != 4'd0);
      showDig[i] = seen;
    end
    showDig[0] = 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_DIG; i++) begin
      if (ctrl.blankAll || !showDig[i]) hexOut[i] = SEG_BLANK;
      else                              hexOut[i] = {1'b1, rawSeg[i]};
    end
    if (!ctrl.blankAll && isNeg) hexOut[NUM_DIG] = SEG_HYPHEN;
    else                         hexOut[NUM_DIG] = SEG_BLANK;
  end

  always_comb begin
    // R1
    blank_all_chk: assert (!ctrl.blankAll ||
      (hexOut[0] == SEG_BLANK && hexOut[NUM_DIG] == SEG_BLANK));
    // R4
    sign_digit_chk: assert ((hexOut[NUM_DIG] == SEG_HYPHEN) == (!ctrl.blankAll && srcVal[PROD_W-1]));
    for (int i = 1; i < NUM_DIG-1; i++) begin
      // R6
      lead_zero_chk: assert (hexOut[i] != SEG_BLANK || hexOut[i+1] == SEG_BLANK);
    end
    for (int i = 0; i <= NUM_DIG; i++) begin
      // R7
      dp_off_chk: assert (hexOut[i][7] == 1'b1);
    end
    // R5
    mag_positive_chk: assert (magVal[PROD_W-1] == 1'b0 || magVal == 16'h8000);
  end
endmodule

// File: rtl/dispFormatter.sv
module dispFormatter
  import dispPkg::*;
(
  input  logic [2:0]  opSel,
  input  logic [15:0] product,
  input  logic [8:0]  arithRes,
  output logic [7:0]  hex0,
  output logic [7:0]  hex1,
  output logic [7:0]  hex2,
  output logic [7:0]  hex3,
  output logic [7:0]  hex4,
  output logic [7:0]  hex5
);
  dispCtrl_t        ctrl;
  logic [SEG_W-1:0] hexOut [NUM_DIG+1];

  dispControl i_ctrl (
    .opSel(opSel),
    .ctrl (ctrl)
  );

  dispDatapath i_dp (
    .ctrl    (ctrl),
    .product (product),
    .arithRes(arithRes),
    .hexOut  (hexOut)
  );

  assign hex0 = hexOut[0];
  assign hex1 = hexOut[1];
  assign hex2 = hexOut[2];
  assign hex3 = hexOut[3];
  assign hex4 = hexOut[4];
  assign hex5 = hexOut[5];
endmodule

// File: tb/test_dispFormatter.sv
module test_dispFormatter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opSel = 3'd0;
  logic [15:0] product = '0;
  logic [8:0]  arithRes = '0;
  logic [7:0]  hex0, hex1, hex2, hex3, hex4, hex5;
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dispFormatter i_dispFormatter (
    .opSel(opSel), .product(product), .arithRes(arithRes),
    .hex0(hex0), .hex1(hex1), .hex2(hex2), .hex3(hex3), .hex4(hex4), .hex5(hex5)
  );

  function automatic logic [7:0] segOf(input int d);
    case (d)
      0: return 8'b11000000;
      1: return 8'b11111001;
      2: return 8'b10100100;
      3: return 8'b10110000;
      4: return 8'b10011001;
      5: return 8'b10010010;
      6: return 8'b10000010;
      7: return 8'b11111000;
      8: return 8'b10000000;
      default: return 8'b10010000;
    endcase
  endfunction

  task automatic checkCase(input logic [2:0] op, input logic [15:0] pr,
                           input logic [8:0] ar, input string req);
    logic [47:0] expV, actV;
    int value, mag, rem;
    bit neg;
    @(posedge clk);
    opSel = op; product = pr; arithRes = ar;
    @(negedge clk);
    if (op < 3'd4) begin
      expV = {6{8'hFF}};
    end else begin
      value = (op == 3'd7) ? int'($signed(pr)) : int'($signed(ar));
      neg = value < 0;
      mag = neg ? -value : value;
      expV[47:40] = neg ? 8'hBF : 8'hFF;
      rem = mag;
      for (int i = 0; i < 5; i++) begin
        if (i > 0 && rem == 0) expV[8*i +: 8] = 8'hFF;
        else                   expV[8*i +: 8] = segOf(rem % 10);
        rem = rem / 10;
      end
    end
    actV = {hex5, hex4, hex3, hex2, hex1, hex0};
    testsRun++;
    if (actV !== expV) begin
      testsFailed++;
      $display("FAIL %s op=%0d prod=%h ar=%h actual=%h expected=%h",
               req, op, pr, ar, actV, expV);
    end
  endtask

  task automatic testReset();
    checkCase(3'd0, 16'h0000, 9'h000, "R1 reset state");
  endtask

  task automatic testLogicBlank();
    checkCase(3'd0, 16'h1234, 9'h0FF, "R1 op0");
    checkCase(3'd1, 16'h8000, 9'h101, "R1 op1");
    checkCase(3'd2, 16'hFFFF, 9'h1FF, "R1 op2");
    checkCase(3'd3, 16'h7FFF, 9'h100, "R1 op3");
  endtask

  task automatic testProduct();
    checkCase(3'd7, 16'd12345, 9'h1FF, "R2 R5 R8 positive product");
    checkCase(3'd7, 16'h7FFF, 9'h000, "R2 R5 max product");
    checkCase(3'd7, 16'h8000, 9'h000, "R2 R4 R5 min product");
    checkCase(3'd7, 16'hFFFF, 9'h0FF, "R2 R4 R6 minus one");
    checkCase(3'd7, 16'd10007, 9'h000, "R5 R6 internal zeros");
    checkCase(3'd7, 16'd65536 - 16'd980, 9'h000, "R2 R4 R6 -980");
  endtask

  task automatic testArith();
    checkCase(3'd4, 16'h8000, 9'h0FF, "R3 +255 product ignored");
    checkCase(3'd5, 16'h7FFF, 9'h100, "R3 R4 -256");
    checkCase(3'd6, 16'h0000, 9'h101, "R3 R4 -255");
    checkCase(3'd4, 16'hFFFF, 9'h1FF, "R3 R4 -1");
    checkCase(3'd5, 16'd999, 9'd60, "R3 R6 60");
  endtask

  task automatic testZeroAndSeg();
    checkCase(3'd4, 16'h0000, 9'h000, "R6 zero shows 0");
    checkCase(3'd7, 16'h0000, 9'h000, "R6 product zero");
    checkCase(3'd7, 16'd8, 9'h000, "R8 numeral 8");
    checkCase(3'd6, 16'h0000, 9'd1, "R8 numeral 1");
  endtask

  task automatic testDp();
    checkCase(3'd7, 16'd88888 - 16'd65536, 9'h000, "R7 dp off");
    testsRun++;
    if ({hex5[7], hex4[7], hex3[7], hex2[7], hex1[7], hex0[7]} !== 6'b111111) begin
      testsFailed++;
      $display("FAIL R7 dp bits actual=%b expected=111111",
               {hex5[7], hex4[7], hex3[7], hex2[7], hex1[7], hex0[7]});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    testReset();
    testLogicBlank();
    testProduct();
    testArith();
    testZeroAndSeg();
    testDp();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule